// File: doc/BRIEF.md
# Oscillator Trim Successive-Approximation Controller

This block tunes the trim code of an on-chip oscillator against a precise external timing pulse. After a start request it sets the trim code to mid-scale. It then measures how many bus clocks, counted in groups of four, fit inside one high phase of the reference input, and compares that figure with a fixed target. From the result it decides whether the oscillator runs slow or fast and moves the trim code by a step that halves on every pass.

A larger trim code slows the oscillator. A measurement below the target therefore lowers the code, and a measurement above it raises the code. The search stops early when a measurement hits the target exactly. Otherwise it stops after a fixed number of passes. At the end the block raises a one-cycle store strobe while the final code is on its trim output, so that neighbouring logic can write the code to non-volatile storage.

Top module: `osc_trim_sar`

## Requirements
- R1: After reset, trim_o is 2^(TRIM_W-1) (0x80 for 8 bits), and busy_o, done_o and store_o are all low.
- R2: A start_i pulse while busy_o is low sets trim_o to 2^(TRIM_W-1), busy_o high and done_o low on the next clock, and sets the pass number to 1.
- R3: A pass measures one reference pulse. The first rising edge of the reference, taken after a SYNC_STAGES-flop synchronizer, opens the pass. The next falling edge closes it. The measured value is the number of prescaler ticks seen while the synchronized reference is high, with one tick on every PRESCALE-th bus clock. A high phase of 4k bus clocks therefore reads as exactly k.
- R4: On pass n, a measured value below EXP_COUNT lowers trim_o by 2^(TRIM_W-1) >> n, and a value above EXP_COUNT raises it by the same amount.
- R5: A measured value equal to EXP_COUNT ends the search on that pass and leaves trim_o unchanged.
- R6: When no pass matches, the search ends after NUM_PASSES passes, with the last adjustment applied.
- R7: When a search ends, store_o is high for exactly one clock. In that same clock done_o is high, busy_o is low and trim_o holds the final code.
- R8: done_o and trim_o hold until the next start_i. Reference pulses arriving while busy_o is low change nothing.
- R9: A start_i received while busy_o is high is ignored. The trim code and the pass sequence continue undisturbed.
- R10: The width counter is ceil(log2(2*EXP_COUNT+1)) bits wide and stops at its all-ones value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration run |
| ref_i | input | 1 | Asynchronous precision reference pulse |
| trim_o | output | TRIM_W | Current trim code for the oscillator |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished; held until next start |
| store_o | output | 1 | One-cycle strobe to save trim_o |

## Verification
The bench builds the block with EXP_COUNT = 20, NUM_PASSES = 8 and an 8-bit trim. This keeps each reference pulse down to a few tens of prescaler ticks, so that dozens of complete calibrations fit in one run. It also makes the 6-bit width counter small enough that a long reference pulse drives it into saturation. A modelled oscillator maps each trim code to a pulse width. Two slopes and a sweep of offsets give both searches that end early on an exact hit and searches that run all eight passes. A constant over-long pulse drives the search to the top code.

// File: rtl/ots_pkg.sv
package ots_pkg;

   typedef enum logic [1:0] {
      CMP_SLOW  = 2'd0,
      CMP_FAST  = 2'd1,
      CMP_MATCH = 2'd2
   } ots_cmp_e;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_MEAS = 1'b1
   } ots_state_e;

endpackage

// File: rtl/ots_ref_meas.sv
module ots_ref_meas #(
   parameter int SYNC_STAGES = 2,
   parameter int PRESCALE    = 4,
   parameter int CNT_W       = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             arm_i,
   input  logic             ref_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             valid_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ref_s, prev_q, rise, fall, tick;
   logic                   running_q;
   logic [CNT_W-1:0]       cnt_q;

   // synchronizer depth chosen by parameter
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= ref_i;
      end else begin : g_syncn
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) sync_q <= '0;
            else         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
      end
   endgenerate

   assign ref_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= ref_s;

   assign rise = ref_s & ~prev_q;
   assign fall = ~ref_s & prev_q;

   // free-running tick divider
   generate
      if (PRESCALE == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PS_W = $clog2(PRESCALE);
         logic [PS_W-1:0] div_q;
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni)                          div_q <= '0;
            else if (div_q == PS_W'(PRESCALE-1))  div_q <= '0;
            else                                  div_q <= div_q + 1'b1;
         assign tick = (div_q == PS_W'(PRESCALE-1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (!arm_i) begin
            running_q <= 1'b0;
         end else if (!running_q) begin
            if (rise) begin
               running_q <= 1'b1;
               cnt_q     <= CNT_W'(tick);
            end
         end else if (fall) begin
            running_q <= 1'b0;
            valid_o   <= 1'b1;
         end else if (tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;

   assert_cnt_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_MAX) && !(arm_i && !running_q && rise) |=> cnt_q == CNT_MAX);

   assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   assert_valid_after_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> !prev_q);

endmodule

// File: rtl/ots_step_calc.sv
module ots_step_calc
   import ots_pkg::*;
#(
   parameter int TRIM_W    = 8,
   parameter int CNT_W     = 10,
   parameter int PASS_W    = 4,
   parameter int EXP_COUNT = 500
) (
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [TRIM_W-1:0] trim_i,
   input  logic [PASS_W-1:0] pass_i,
   output ots_cmp_e          cmp_o,
   output logic [TRIM_W-1:0] trim_next_o
);
   localparam logic [TRIM_W-1:0] HALF  = TRIM_W'(1) << (TRIM_W-1);
   localparam logic [CNT_W-1:0]  EXP_C = CNT_W'(EXP_COUNT);

   logic [TRIM_W-1:0] step;

   assign step = HALF >> pass_i;

   always_comb begin
      if (cnt_i == EXP_C)     cmp_o = CMP_MATCH;
      else if (cnt_i < EXP_C) cmp_o = CMP_SLOW;
      else                    cmp_o = CMP_FAST;
   end

   // slow oscillator -> lower code raises frequency
   always_comb begin
      unique case (cmp_o)
         CMP_SLOW: trim_next_o = trim_i - step;
         CMP_FAST: trim_next_o = trim_i + step;
         default:  trim_next_o = trim_i;
      endcase
   end

endmodule

// File: rtl/osc_trim_sar.sv
module osc_trim_sar
   import ots_pkg::*;
#(
   parameter int TRIM_W      = 8,
   parameter int EXP_COUNT   = 500,
   parameter int NUM_PASSES  = 8,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              ref_i,
   output logic [TRIM_W-1:0] trim_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              store_o
);
   localparam int CNT_W  = $clog2(2*EXP_COUNT+1);
   localparam int PASS_W = $clog2(NUM_PASSES+1);
   localparam logic [TRIM_W-1:0] HALF     = TRIM_W'(1) << (TRIM_W-1);
   localparam logic [PASS_W-1:0] LAST_PAS = PASS_W'(NUM_PASSES);

   generate
      if (TRIM_W < 2)       begin : g_chk_tw  $error("TRIM_W must be at least 2");       end
      if (EXP_COUNT < 1)    begin : g_chk_exp $error("EXP_COUNT must be positive");      end
      if (NUM_PASSES < 1)   begin : g_chk_np  $error("NUM_PASSES must be positive");     end
      if (PRESCALE < 1)     begin : g_chk_ps  $error("PRESCALE must be positive");       end
      if (SYNC_STAGES < 1)  begin : g_chk_ss  $error("SYNC_STAGES must be positive");    end
   endgenerate

   ots_state_e        state_q;
   logic [TRIM_W-1:0] trim_q, trim_next;
   logic [PASS_W-1:0] pass_q;
   logic [CNT_W-1:0]  meas_cnt;
   logic              meas_valid;
   ots_cmp_e          cmp;

   ots_ref_meas #(
      .SYNC_STAGES (SYNC_STAGES),
      .PRESCALE    (PRESCALE),
      .CNT_W       (CNT_W)
   ) u_meas (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .arm_i   (state_q == ST_MEAS),
      .ref_i   (ref_i),
      .cnt_o   (meas_cnt),
      .valid_o (meas_valid)
   );

   ots_step_calc #(
      .TRIM_W    (TRIM_W),
      .CNT_W     (CNT_W),
      .PASS_W    (PASS_W),
      .EXP_COUNT (EXP_COUNT)
   ) u_step (
      .cnt_i       (meas_cnt),
      .trim_i      (trim_q),
      .pass_i      (pass_q),
      .cmp_o       (cmp),
      .trim_next_o (trim_next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         trim_q  <= HALF;
         pass_q  <= '0;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
         store_o <= 1'b0;
      end else begin
         store_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  trim_q  <= HALF;
                  pass_q  <= PASS_W'(1);
                  busy_o  <= 1'b1;
                  done_o  <= 1'b0;
                  state_q <= ST_MEAS;
               end
            end
            ST_MEAS: begin
               if (meas_valid) begin
                  trim_q <= trim_next;
                  if (cmp == CMP_MATCH || pass_q == LAST_PAS) begin
                     state_q <= ST_IDLE;
                     busy_o  <= 1'b0;
                     done_o  <= 1'b1;
                     store_o <= 1'b1;
                  end else begin
                     pass_q <= pass_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign trim_o = trim_q;

   assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o |=> busy_o && !done_o && trim_o == HALF);

   assert_slow_lowers_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && meas_valid && meas_cnt < CNT_W'(EXP_COUNT) |=> trim_o <= $past(trim_o));

   assert_fast_raises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && meas_valid && meas_cnt > CNT_W'(EXP_COUNT) |=> trim_o >= $past(trim_o));

   assert_match_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && meas_valid && meas_cnt == CNT_W'(EXP_COUNT) |=> store_o && $stable(trim_o));

   assert_pass_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> pass_q >= PASS_W'(1) && pass_q <= LAST_PAS);

   assert_store_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      store_o |-> done_o && !busy_o);

   assert_store_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      store_o |=> !store_o);

   assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o && !start_i |=> done_o && $stable(trim_o));

   assert_busy_trim_still_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !meas_valid |=> $stable(trim_o) && busy_o);

endmodule

// File: tb/sim_osc_trim_sar.sv
`timescale 1ns/1ps
module sim_osc_trim_sar;
   localparam int EXP  = 20;
   localparam int NP   = 8;
   localparam int TW   = 8;
   localparam int CW   = $clog2(2*EXP+1);
   localparam int CMAX = (1 << CW) - 1;
   localparam int HALF = 1 << (TW-1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          refp = 1'b0;
   logic [TW-1:0] trim_o;
   logic          busy_o, done_o, store_o;

   int n_chk = 0;
   int n_fail = 0;
   int store_cnt = 0;
   int store_val = 0;

   always #4 clk = ~clk;

   osc_trim_sar #(
      .TRIM_W(TW), .EXP_COUNT(EXP), .NUM_PASSES(NP), .PRESCALE(4), .SYNC_STAGES(2)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_i(refp),
      .trim_o(trim_o), .busy_o(busy_o), .done_o(done_o), .store_o(store_o)
   );

   always @(negedge clk)
      if (store_o) begin
         store_cnt = store_cnt + 1;
         store_val = int'(trim_o);
      end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // oscillator model: measured value for a given trim code (higher code -> fewer ticks)
   function automatic int osc_count(input int mode, input int c0, input int t);
      int c;
      case (mode)
         0:       c = c0 - (t >> 4);
         1:       c = c0 - (t >> 3);
         default: c = 80;
      endcase
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic void ref_cal(input int mode, input int c0,
                                   output int ft, output int np, output bit hit);
      int t;
      t = HALF; np = 0; hit = 1'b0;
      for (int n = 1; n <= NP; n++) begin
         int c;
         c = osc_count(mode, c0, t);
         if (c > CMAX) c = CMAX;
         np = n;
         if (c == EXP) begin
            hit = 1'b1;
            break;
         end
         if (c < EXP) t = t - (HALF >> n);
         else         t = t + (HALF >> n);
      end
      ft = t;
   endfunction

   task automatic run_cal(input int mode, input int c0, input bit poke);
      int ft, np, pulses, w, held;
      bit hit;
      string tag;
      ref_cal(mode, c0, ft, np, hit);
      store_cnt = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R2 busy after start", int'(busy_o), 1);
      chk("R2 trim mid-scale", int'(trim_o), HALF);
      pulses = 0;
      while (!done_o && pulses < 20) begin
         repeat (12) @(negedge clk);
         if (done_o) break;
         if (poke && pulses == 2) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
         end
         w = 4 * osc_count(mode, c0, int'(trim_o));
         refp = 1'b1;
         repeat (w) @(negedge clk);
         refp = 1'b0;
         pulses = pulses + 1;
      end
      tag = (mode == 2) ? "R10 saturated" : (poke ? "R9 start ignored" : "R3 R4 sweep");
      chk({tag, " final trim"}, int'(trim_o), ft);
      chk(hit ? "R5 early stop passes" : "R6 full passes", pulses, np);
      chk("R7 one store strobe", store_cnt, 1);
      chk("R7 store carries trim", store_val, ft);
      chk("R7 done and not busy", int'(done_o) * 2 + int'(busy_o), 2);
      // idle: done holds, reference pulses ignored
      held = int'(trim_o);
      repeat (30) @(negedge clk);
      refp = 1'b1;
      repeat (40) @(negedge clk);
      refp = 1'b0;
      repeat (12) @(negedge clk);
      chk("R8 done held", int'(done_o), 1);
      chk("R8 trim held idle", int'(trim_o), held);
      chk("R8 no extra store", store_cnt, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset trim", int'(trim_o), HALF);
      chk("R1 reset busy", int'(busy_o), 0);
      chk("R1 reset done", int'(done_o), 0);
      chk("R1 reset store", int'(store_o), 0);
      for (int m = 0; m < 2; m++)
         for (int c0 = 15; c0 <= 40; c0++)
            run_cal(m, c0, 1'b0);
      run_cal(0, 30, 1'b1);
      run_cal(1, 23, 1'b1);
      run_cal(2, 0, 1'b0);
      // next start clears done
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R8 done cleared by start", int'(done_o), 0);
      chk("R2 busy on restart", int'(busy_o), 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule